// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight edge-triggered interrupt requests. It picks the most urgent one by fixed priority, with input 0 the most urgent and input 7 the least. It raises a single interrupt output to the host processor, and on an acknowledge pulse it returns an 8-bit vector that identifies the winning input. Software reaches the block through two addresses. The command address starts configuration, carries end-of-interrupt and read-select commands, and reads back the pending or in-service register. The data address carries the configuration words and, once configured, the mask register.

A configuration run starts when software writes a command byte with bit 4 set. That byte can announce that the controller is part of a chain, and that a final options word follows. The data writes after it then give, in this order: the vector base, the chain map (chained runs only), and the options word (only when announced). Two instances can be chained. A master is told which of its inputs carry a slave. When the master acknowledges such an input, it forwards the acknowledge to the slave and takes the slave's own resolved vector.

When a request vanishes before it is acknowledged, the controller answers with the vector of input 7 and leaves the in-service register untouched. Software treats that vector as a spurious interrupt.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, command reads select the pending register (which reads 0x00), the interrupt output and the vector-valid output are low, the vector base is 0, and the controller runs unchained with normal end-of-interrupt.
- R2: A command write with bit 4 set clears the pending and in-service registers and selects pending read-back. The following data writes are taken as the vector base (bits 7:3), then the chain map if bit 1 of the first word was 0, then the options word if bit 0 of the first word was 1. These writes leave the mask unchanged.
- R3: Outside configuration, a data write loads the mask and a data read returns it. A set mask bit keeps its input from raising the interrupt output, and the input's pending bit is still recorded.
- R4: Command write 0x0A selects the pending register for command reads and 0x0B selects the in-service register. The selection lasts until changed, and a command write of 0x08 keeps it.
- R5: A rising input sets its pending bit at the next clock edge. The bit stays set while the input is high and clears when the input falls or the request is acknowledged. The interrupt output follows one cycle after the rising edge.
- R6: The winner is the lowest-numbered input that is both pending and unmasked. The interrupt output is high only when the winner is more urgent than every in-service input.
- R7: An acknowledge pulse with a winner present clears the winner's pending bit and sets its in-service bit. One cycle later the vector output equals base*8+winner, with vector-valid high for that one cycle.
- R8: When bit 1 of the options word is set (automatic end-of-interrupt), an acknowledge sets no in-service bit.
- R9: Command write 0x60+L (L from 0 to 7) clears in-service bit L and no other bit.
- R10: An acknowledge with no winner returns base*8+7 and changes no in-service bit, whatever the mask of input 7.
- R11: In a chained run with masterMode high, acknowledging an input whose chain-map bit is set raises cascAck in that cycle, and the vector output then equals cascVec. Otherwise cascAck stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Host write strobe, one cycle per write |
| busAddr | input | 1 | 0 = command address, 1 = data address |
| busWrData | input | 8 | Host write data |
| busRdData | output | 8 | Read data for the address on busAddr (combinational) |
| irqReq | input | 8 | Interrupt request inputs |
| masterMode | input | 1 | High when this instance is a chain master |
| intReq | output | 1 | Interrupt output to the processor |
| ackPulse | input | 1 | One-cycle acknowledge from the processor |
| vecOut | output | 8 | Vector latched by the last acknowledge |
| vecValid | output | 1 | High for one cycle when vecOut is new |
| nextVec | output | 8 | Vector the next acknowledge would return (for a master) |
| cascVec | input | 8 | Slave's nextVec, used for chained inputs |
| cascAck | output | 1 | Acknowledge forwarded to the slave |

## Verification
A host write takes effect at the clock edge that ends its write cycle. Reads are combinational, so a register read is checked at the falling edge straight after the write. A rising request input shows on the interrupt output at the falling edge after the next rising edge. After an acknowledge, the vector and the one-cycle valid flag appear one edge later, while the forwarded chain acknowledge is checked within the acknowledge cycle itself. The bench applies every stimulus on a falling edge and samples at the next one, and a monitor pops expected vectors from a scoreboard queue only on the cycle in which vector-valid is high.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NUM_IN = 8;
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(NUM_IN);
  localparam int BASE_W = DATA_W - IDX_W;

  typedef struct packed {
    logic             initClr;
    logic             eoiStb;
    logic [IDX_W-1:0] eoiLvl;
  } ctrl_strobes_t;

  typedef enum logic [1:0] {ST_RUN, ST_W2, ST_W3, ST_W4} init_state_t;
endpackage

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic                 busAddr,
  input  logic [DATA_W-1:0]    busWrData,
  input  logic                 masterMode,
  input  logic [NUM_IN-1:0]    irrVec,
  input  logic [NUM_IN-1:0]    isrVec,
  output logic [DATA_W-1:0]    busRdData,
  output ctrl_strobes_t        strobes,
  output logic [NUM_IN-1:0]    maskVec,
  output logic [BASE_W-1:0]    vecBase,
  output logic [NUM_IN-1:0]    casEn,
  output logic                 aeoiEn,
  output logic                 cfgBusy
);
  init_state_t       state;
  logic              singleMode;
  logic              needW4;
  logic              readIsr;
  logic [NUM_IN-1:0] casMap;
  logic              cmdWr;
  logic              dataWr;
  logic              startInit;

  assign cmdWr     = busWr && !busAddr;
  assign dataWr    = busWr && busAddr;
  assign startInit = cmdWr && busWrData[4];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_RUN;
      singleMode <= 1'b1;
      needW4     <= 1'b0;
      aeoiEn     <= 1'b0;
      readIsr    <= 1'b0;
      casMap     <= '0;
      maskVec    <= '1;
      vecBase    <= '0;
    end else if (startInit) begin
      state      <= ST_W2;
      singleMode <= busWrData[1];
      needW4     <= busWrData[0];
      aeoiEn     <= 1'b0;
      readIsr    <= 1'b0;
      casMap     <= '0;
    end else if (dataWr) begin
      case (state)
        ST_W2: begin
          vecBase <= busWrData[DATA_W-1:IDX_W];
          if (!singleMode) state <= ST_W3;
          else if (needW4) state <= ST_W4;
          else             state <= ST_RUN;
        end
        ST_W3: begin
          casMap <= busWrData[NUM_IN-1:0];
          state  <= needW4 ? ST_W4 : ST_RUN;
        end
        ST_W4: begin
          aeoiEn <= busWrData[1];
          state  <= ST_RUN;
        end
        default: maskVec <= busWrData[NUM_IN-1:0];
      endcase
    end else if (cmdWr && state == ST_RUN && busWrData[3] && busWrData[1]) begin
      readIsr <= busWrData[0];
    end
  end

  always_comb begin
    strobes.initClr = startInit;
    strobes.eoiStb  = cmdWr && !busWrData[4] && !busWrData[3] &&
                      (busWrData[7:5] == 3'b011) && (state == ST_RUN);
    strobes.eoiLvl  = busWrData[IDX_W-1:0];
  end

  assign casEn     = (!singleMode && masterMode) ? casMap : '0;
  assign cfgBusy   = (state != ST_RUN);
  assign busRdData = busAddr ? maskVec : (readIsr ? isrVec : irrVec);
endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_strobes_t        strobes,
  input  logic [NUM_IN-1:0]    irqReq,
  input  logic [NUM_IN-1:0]    maskVec,
  input  logic [BASE_W-1:0]    vecBase,
  input  logic [NUM_IN-1:0]    casEn,
  input  logic                 aeoiEn,
  input  logic                 ackPulse,
  input  logic [DATA_W-1:0]    cascVec,
  output logic [NUM_IN-1:0]    irrVec,
  output logic [NUM_IN-1:0]    isrVec,
  output logic                 intReq,
  output logic [DATA_W-1:0]    vecOut,
  output logic                 vecValid,
  output logic [DATA_W-1:0]    nextVec,
  output logic                 cascAck
);
  logic [NUM_IN-1:0] irqPrev;
  logic [NUM_IN-1:0] eligible;
  logic [NUM_IN-1:0] takeMask;
  logic [NUM_IN-1:0] eoiMask;
  logic [IDX_W-1:0]  winIdx;
  logic              found;
  logic              blocked;
  logic              winValid;
  logic              ackTake;

  // fixed priority: lowest index wins, blocked by equal or more urgent service
  always_comb begin
    eligible = irrVec & ~maskVec;
    found    = 1'b0;
    winIdx   = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        found  = 1'b1;
        winIdx = IDX_W'(i);
      end
    end
    blocked = 1'b0;
    for (int j = 0; j < NUM_IN; j++) begin
      if (isrVec[j] && (IDX_W'(j) <= winIdx)) blocked = 1'b1;
    end
    winValid = found && !blocked;
  end

  assign ackTake  = ackPulse && winValid;
  assign takeMask = (ackTake && !aeoiEn) ? (NUM_IN'(1) << winIdx) : '0;
  assign eoiMask  = strobes.eoiStb ? (NUM_IN'(1) << strobes.eoiLvl) : '0;
  assign intReq   = winValid;
  assign cascAck  = ackTake && casEn[winIdx];
  assign nextVec  = {vecBase, (winValid ? winIdx : IDX_W'(NUM_IN - 1))};

  always_ff @(posedge clk) begin
    if (!rstN) irqPrev <= '0;
    else       irqPrev <= irqReq;
  end

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_req
    logic reqBit;
    always_ff @(posedge clk) begin
      if (!rstN || strobes.initClr)            reqBit <= 1'b0;
      else if (!irqReq[gi])                    reqBit <= 1'b0;
      else if (!irqPrev[gi])                   reqBit <= 1'b1;
      else if (ackTake && winIdx == IDX_W'(gi)) reqBit <= 1'b0;
    end
    assign irrVec[gi] = reqBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.initClr) isrVec <= '0;
    else                          isrVec <= (isrVec & ~eoiMask) | takeMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      vecValid <= ackPulse;
      if (ackPulse) vecOut <= (winValid && casEn[winIdx]) ? cascVec : nextVec;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [NUM_IN-1:0] irqReq,
  input  logic              masterMode,
  output logic              intReq,
  input  logic              ackPulse,
  output logic [DATA_W-1:0] vecOut,
  output logic              vecValid,
  output logic [DATA_W-1:0] nextVec,
  input  logic [DATA_W-1:0] cascVec,
  output logic              cascAck
);
  ctrl_strobes_t     strobes;
  logic [NUM_IN-1:0] maskVec;
  logic [NUM_IN-1:0] irrVec;
  logic [NUM_IN-1:0] isrVec;
  logic [NUM_IN-1:0] casEn;
  logic [BASE_W-1:0] vecBase;
  logic              aeoiEn;
  logic              cfgBusy;

  pic_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .masterMode(masterMode), .irrVec(irrVec),
    .isrVec(isrVec), .busRdData(busRdData), .strobes(strobes),
    .maskVec(maskVec), .vecBase(vecBase), .casEn(casEn),
    .aeoiEn(aeoiEn), .cfgBusy(cfgBusy)
  );

  pic_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .irqReq(irqReq),
    .maskVec(maskVec), .vecBase(vecBase), .casEn(casEn), .aeoiEn(aeoiEn),
    .ackPulse(ackPulse), .cascVec(cascVec), .irrVec(irrVec),
    .isrVec(isrVec), .intReq(intReq), .vecOut(vecOut),
    .vecValid(vecValid), .nextVec(nextVec), .cascAck(cascAck)
  );
endmodule

// File: rtl/pic_checker.sv
module pic_checker
  import pic_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic              busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic              masterMode,
  input logic              intReq,
  input logic              ackPulse,
  input logic [DATA_W-1:0] vecOut,
  input logic              vecValid,
  input logic [DATA_W-1:0] cascVec,
  input logic              cascAck,
  input logic [NUM_IN-1:0] isrVec,
  input logic              aeoiEn,
  input logic              cfgBusy
);
  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr && !cfgBusy) |=> (!busAddr || busRdData == $past(busWrData)));

  assert_isr_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ackPulse && intReq && !aeoiEn && !busWr) |=>
      ($countones(isrVec) == $past($countones(isrVec)) + 1));

  assert_auto_eoi_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ackPulse && aeoiEn && !busWr) |=> $stable(isrVec));

  assert_eoi_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busAddr && !cfgBusy && busWrData[7:3] == 5'b01100 && !ackPulse) |=>
      (((isrVec >> $past(busWrData[2:0])) & NUM_IN'(1)) == '0));

  assert_spurious_vec_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ackPulse && !intReq) |=> (vecValid && vecOut[2:0] == 3'd7));

  assert_casc_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    cascAck |-> (ackPulse && intReq && masterMode));

  assert_casc_vec_R11: assert property (@(posedge clk) disable iff (!rstN)
    cascAck |=> (vecOut == $past(cascVec)));
endmodule

bind prio_irq_ctrl pic_checker u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
  .busWrData(busWrData), .busRdData(busRdData), .masterMode(masterMode),
  .intReq(intReq), .ackPulse(ackPulse), .vecOut(vecOut),
  .vecValid(vecValid), .cascVec(cascVec), .cascAck(cascAck),
  .isrVec(isrVec), .aeoiEn(aeoiEn), .cfgBusy(cfgBusy)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWr = 1'b0;
  logic       busAddr = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic [7:0] irqReq = 8'h00;
  logic       masterMode = 1'b1;
  logic       intReq;
  logic       ackPulse = 1'b0;
  logic [7:0] vecOut;
  logic       vecValid;
  logic [7:0] nextVec;
  logic [7:0] cascVec = 8'h4B;
  logic       cascAck;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #10 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irqReq(irqReq),
    .masterMode(masterMode), .intReq(intReq), .ackPulse(ackPulse),
    .vecOut(vecOut), .vecValid(vecValid), .nextVec(nextVec),
    .cascVec(cascVec), .cascAck(cascAck)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    busWr = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdChk(input logic a, input logic [7:0] exp, input string tag);
    busAddr = a;
    #1;
    chk(tag, busRdData, exp);
  endtask

  task automatic irqSet(input int idx, input logic v);
    irqReq[idx] = v;
    @(negedge clk);
  endtask

  task automatic ackChk(input logic [7:0] ev, input logic expCas, input string tag);
    expQ.push_back(ev);
    tagQ.push_back(tag);
    ackPulse = 1'b1;
    #1;
    chk({tag, " cascAck"}, {7'd0, cascAck}, {7'd0, expCas});
    @(negedge clk);
    ackPulse = 1'b0;
    @(negedge clk);
  endtask

  // monitor: scoreboard of acknowledged vectors
  always @(negedge clk) begin
    if (rstN && vecValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 unexpected vector actual=%h expected=none", vecOut);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, vecOut, e);
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 intReq", {7'd0, intReq}, 8'h00);
    chk("R1 vecValid", {7'd0, vecValid}, 8'h00);
    rdChk(1'b1, 8'hFF, "R1 mask");
    rdChk(1'b0, 8'h00, "R1 irr");
    chk("R1 nextVec", nextVec, 8'h07);

    // R2 chained configuration, base 0x20, slave on input 2, options word
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h20);
    wr(1'b1, 8'h04);
    wr(1'b1, 8'h01);
    rdChk(1'b1, 8'hFF, "R2 mask untouched by config");
    wr(1'b1, 8'h00);
    rdChk(1'b1, 8'h00, "R3 mask load");

    // R5 edge capture, R7 acknowledge
    irqSet(5, 1'b1);
    chk("R5 intReq after edge", {7'd0, intReq}, 8'h01);
    rdChk(1'b0, 8'h20, "R5 irr");
    ackChk(8'h25, 1'b0, "R7 vector input5");
    wr(1'b0, 8'h0B);
    rdChk(1'b0, 8'h20, "R7 isr after ack");
    wr(1'b0, 8'h0A);
    rdChk(1'b0, 8'h00, "R7 irr cleared");
    wr(1'b0, 8'h0B);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h08);
    rdChk(1'b0, 8'h20, "R4 isr select persists");

    // R6 nesting
    irqSet(6, 1'b1);
    chk("R6 lower blocked", {7'd0, intReq}, 8'h00);
    irqSet(3, 1'b1);
    chk("R6 higher passes", {7'd0, intReq}, 8'h01);
    ackChk(8'h23, 1'b0, "R6 vector input3");
    rdChk(1'b0, 8'h28, "R6 isr nested");

    // R9 specific end of interrupt
    wr(1'b0, 8'h63);
    rdChk(1'b0, 8'h20, "R9 eoi level3");
    chk("R9 still blocked", {7'd0, intReq}, 8'h00);
    wr(1'b0, 8'h65);
    rdChk(1'b0, 8'h00, "R9 eoi level5");
    chk("R9 pending six released", {7'd0, intReq}, 8'h01);
    ackChk(8'h26, 1'b0, "R7 vector input6");
    wr(1'b0, 8'h66);
    rdChk(1'b0, 8'h00, "R9 eoi level6");
    irqReq = 8'h00;
    @(negedge clk);

    // R3 masking
    wr(1'b1, 8'h02);
    irqSet(1, 1'b1);
    chk("R3 masked no int", {7'd0, intReq}, 8'h00);
    wr(1'b0, 8'h0A);
    rdChk(1'b0, 8'h02, "R3 masked still pending");
    wr(1'b1, 8'h00);
    chk("R3 unmasked int", {7'd0, intReq}, 8'h01);

    // R5 vanish, R10 spurious
    irqSet(1, 1'b0);
    chk("R5 vanish drops int", {7'd0, intReq}, 8'h00);
    rdChk(1'b0, 8'h00, "R5 vanish irr");
    ackChk(8'h27, 1'b0, "R10 spurious vector");
    wr(1'b0, 8'h0B);
    rdChk(1'b0, 8'h00, "R10 isr unchanged");
    wr(1'b1, 8'hFF);
    ackChk(8'h27, 1'b0, "R10 spurious with input7 masked");
    rdChk(1'b0, 8'h00, "R10 isr unchanged masked");
    wr(1'b1, 8'h00);

    // R11 cascade input
    irqSet(2, 1'b1);
    chk("R11 int for cascade", {7'd0, intReq}, 8'h01);
    chk("R11 cascAck idle", {7'd0, cascAck}, 8'h00);
    ackChk(8'h4B, 1'b1, "R11 slave vector");
    rdChk(1'b0, 8'h04, "R11 isr cascade input");
    wr(1'b0, 8'h62);
    rdChk(1'b0, 8'h00, "R9 eoi cascade");
    irqSet(2, 1'b0);

    // R2 reconfigure clears pending, single mode with auto eoi
    wr(1'b1, 8'hFF);
    wr(1'b0, 8'h0A);
    irqSet(0, 1'b1);
    rdChk(1'b0, 8'h01, "R2 pending before config");
    wr(1'b0, 8'h13);
    rdChk(1'b0, 8'h00, "R2 config clears irr");
    wr(1'b1, 8'h40);
    wr(1'b1, 8'h02);
    rdChk(1'b1, 8'hFF, "R2 mask kept");
    irqSet(0, 1'b0);
    wr(1'b1, 8'h00);
    irqSet(4, 1'b1);
    ackChk(8'h44, 1'b0, "R8 vector base 0x40");
    wr(1'b0, 8'h0B);
    rdChk(1'b0, 8'h00, "R8 auto eoi isr empty");
    chk("R8 int low after ack", {7'd0, intReq}, 8'h00);
    irqSet(2, 1'b1);
    ackChk(8'h42, 1'b0, "R11 single mode no cascade");
    irqReq = 8'h00;
    repeat (3) @(negedge clk);

    chk("R7 scoreboard drained", 8'(expQ.size()), 8'h00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule